// File: doc/BRIEF.md
# Vector Upper-Half Warmup Sequencer

This block sits between instruction issue and a 256-bit SIMD add datapath that is built from two 128-bit halves. The upper half is kept idle until wide vector work shows up. While it is idle, every 256-bit operation is split into two back-to-back passes through the lower half, and each result comes back later than it would with the whole datapath running. Once wide work has been seen, a warmup interval runs. After that interval, 256-bit operations issue in a single pass at full rate. A long quiet stretch turns the upper half off again.

The issue side uses a valid/ready handshake. For each pass the block reports which operand halves are in use. Results leave through a single retire port. Each operation's latency and pass pattern are fixed in the cycle it is accepted. A state output shows the sequencer's current condition, and the arithmetic is a lane-wise wrapping add.

Top module: `vec_warm_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the state is COLD (0), issue_ready_o is high, and pass_valid_o and res_valid_o are low.
- R2: A 256-bit operation accepted in COLD moves the state to WARMING (1) on the next cycle. The state becomes WARM (2) after exactly WARMUP_CYC cycles in WARMING, whatever traffic arrives.
- R3: A 256-bit operation accepted while the state is not WARM produces two passes in the two cycles that follow the accept: pass_sel_o 2'b01 (low operand half), then 2'b10 (high operand half routed through the lower unit). issue_ready_o is low in the first of those cycles.
- R4: A 256-bit operation accepted in WARM produces a single pass with pass_sel_o 2'b11 in the next cycle and does not lower issue_ready_o.
- R5: A 128-bit operation produces a single pass with pass_sel_o 2'b01 in the next cycle in every state, and it never starts warmup.
- R6: With the accept cycle counted as 0, res_valid_o rises in cycle WARM_LAT for an operation accepted in WARM, in cycle WARM_LAT+COLD_EXTRA for a 128-bit operation accepted in any other state, and in cycle WARM_LAT+COLD_EXTRA+2 for a 256-bit operation accepted in any other state. The +2 covers the second pass and the move of the low result into the high half.
- R7: An operation accepted before the state reaches WARM keeps its split passes and its longer latency, even if the state changes while it is in flight.
- R8: In WARM, IDLE_CYC consecutive cycles with no accepted operation return the state to COLD on the next cycle. Any accepted operation restarts that count.
- R9: res_data_o is the sum of the two operands in independent LANE_W-bit lanes, each wrapping modulo 2^LANE_W. For a 128-bit operation, bits 255:128 of the result are zero.
- R10: issue_ready_o is low whenever the offered operation's retire cycle is already held by an earlier operation. No two results retire in the same cycle.
- R11: state_o only ever shows 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | An operation is offered |
| issue_wide_i | input | 1 | 1: 256-bit operation, 0: 128-bit operation |
| issue_a_i | input | 256 | First operand |
| issue_b_i | input | 256 | Second operand |
| issue_ready_o | output | 1 | The offered operation can be taken this cycle |
| pass_valid_o | output | 1 | A pass is on the datapath |
| pass_sel_o | output | 2 | Operand halves in use: bit 0 low half, bit 1 high half |
| res_valid_o | output | 1 | A result retires this cycle |
| res_data_o | output | 256 | Retiring result |
| state_o | output | 2 | 0 COLD, 1 WARMING, 2 WARM |

## Verification
Two events can fall in the same cycle: a short-latency operation taken right after WARM is reached, and the retire cycle still held by a cold operation accepted a few cycles earlier. A cold 256-bit operation followed two cycles later by a cold 128-bit one hits the same clash. The bench keeps valid high with mixed widths from before warmup begins until well after it ends, so these clashes occur at the transition. Its model predicts the retire cycle of every accepted operation and compares ready, passes, state and result on every clock. A missed stall therefore shows up as a ready mismatch or as a result in the wrong cycle.

// File: rtl/vws_pkg.sv
package vws_pkg;
  typedef enum logic [1:0] {
    ST_COLD    = 2'd0,
    ST_WARMING = 2'd1,
    ST_WARM    = 2'd2
  } vws_state_e;
endpackage

// File: rtl/vws_ctrl.sv
module vws_ctrl
  import vws_pkg::*;
#(
  parameter int unsigned WARMUP_CYC = 70,
  parameter int unsigned IDLE_CYC   = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_i,
  input  logic       acc_wide_i,
  output vws_state_e state_o
);
  localparam int unsigned CNT_MAX = (WARMUP_CYC > IDLE_CYC) ? WARMUP_CYC : IDLE_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARMUP_CYC - 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYC - 1);

  vws_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_COLD: begin
        cnt_d = '0;
        if (acc_i && acc_wide_i) state_d = ST_WARMING;
      end
      ST_WARMING: begin
        if (cnt_q == WARM_LAST) begin
          state_d = ST_WARM;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WARM: begin
        if (acc_i) begin
          cnt_d = '0;
        end else if (cnt_q == IDLE_LAST) begin
          state_d = ST_COLD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_COLD;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_COLD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  assert_cold_exit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COLD && acc_i && acc_wide_i) |=> state_q == ST_WARMING);
  assert_no_skip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COLD) |=> state_q != ST_WARM);
  assert_narrow_no_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COLD && !(acc_i && acc_wide_i)) |=> state_q == ST_COLD);
  assert_busy_keeps_warm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WARM && acc_i) |=> state_q == ST_WARM);
  assert_legal_state_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'd3);
endmodule

// File: rtl/vws_lane_add.sv
module vws_lane_add #(
  parameter int unsigned HALF_W = 128,
  parameter int unsigned LANE_W = 32
) (
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  output logic [HALF_W-1:0] sum_o
);
  localparam int unsigned LANES = HALF_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign sum_o[l*LANE_W +: LANE_W] = a_i[l*LANE_W +: LANE_W] + b_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/vws_result_pipe.sv
module vws_result_pipe #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 256,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              book_i,
  input  logic [IDX_W-1:0]  book_idx_i,
  input  logic [IDX_W-1:0]  probe_idx_i,
  output logic              busy_o,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o
);
  // slot k retires k cycles from now
  logic [DEPTH-1:0]  rsv_q;
  logic [DATA_W-1:0] dat_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic              rsv_up;
    logic [DATA_W-1:0] dat_up;
    if (k == DEPTH - 1) begin : g_top
      assign rsv_up = 1'b0;
      assign dat_up = '0;
    end else begin : g_mid
      assign rsv_up = rsv_q[k+1];
      assign dat_up = dat_q[k+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rsv_q[k] <= 1'b0;
        dat_q[k] <= '0;
      end else begin
        rsv_q[k] <= rsv_up | (book_i && book_idx_i == IDX_W'(k));
        dat_q[k] <= (wr_i && wr_idx_i == IDX_W'(k)) ? wr_data_i : dat_up;
      end
    end
  end

  assign busy_o      = rsv_q[probe_idx_i];
  assign res_valid_o = rsv_q[0];
  assign res_data_o  = dat_q[0];

  assert_wr_booked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> rsv_q[wr_idx_i + IDX_W'(1)]);
  assert_book_free_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    book_i |=> $countones(rsv_q) == $countones($past(rsv_q) >> 1) + 1);
endmodule

// File: rtl/vec_warm_seq.sv
module vec_warm_seq
  import vws_pkg::*;
#(
  parameter int unsigned HALF_W     = 128,
  parameter int unsigned LANE_W     = 32,
  parameter int unsigned WARM_LAT   = 3,
  parameter int unsigned COLD_EXTRA = 2,
  parameter int unsigned WARMUP_CYC = 70,
  parameter int unsigned IDLE_CYC   = 1024
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                issue_valid_i,
  input  logic                issue_wide_i,
  input  logic [2*HALF_W-1:0] issue_a_i,
  input  logic [2*HALF_W-1:0] issue_b_i,
  output logic                issue_ready_o,
  output logic                pass_valid_o,
  output logic [1:0]          pass_sel_o,
  output logic                res_valid_o,
  output logic [2*HALF_W-1:0] res_data_o,
  output logic [1:0]          state_o
);
  localparam int unsigned DATA_W     = 2 * HALF_W;
  localparam int unsigned LAT_COLD_N = WARM_LAT + COLD_EXTRA;
  localparam int unsigned LAT_COLD_W = LAT_COLD_N + 2;
  localparam int unsigned DEPTH      = LAT_COLD_W + 1;
  localparam int unsigned IDX_W      = $clog2(DEPTH);

  vws_state_e state;
  logic       cold_now, accept, slot_busy, second_pend;
  logic [IDX_W-1:0] offer_lat;

  // operation held for its passes
  logic              p_valid_q, p_phase_q, p_split_q, p_wide_q;
  logic [IDX_W-1:0]  p_lat_q;
  logic [DATA_W-1:0] op_a_q, op_b_q;
  logic [HALF_W-1:0] lo_hold_q;

  logic [HALF_W-1:0] lo_a, lo_b, lo_sum, hi_sum;
  logic              wr;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  vws_ctrl #(
    .WARMUP_CYC (WARMUP_CYC),
    .IDLE_CYC   (IDLE_CYC)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (accept),
    .acc_wide_i (issue_wide_i),
    .state_o    (state)
  );

  assign cold_now  = (state != ST_WARM);
  assign offer_lat = !cold_now   ? IDX_W'(WARM_LAT)   :
                     issue_wide_i ? IDX_W'(LAT_COLD_W) : IDX_W'(LAT_COLD_N);

  assign second_pend   = p_valid_q && p_split_q && !p_phase_q;
  assign issue_ready_o = !second_pend && !slot_busy;
  assign accept        = issue_valid_i && issue_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_valid_q <= 1'b0;
      p_phase_q <= 1'b0;
      p_split_q <= 1'b0;
      p_wide_q  <= 1'b0;
      p_lat_q   <= '0;
      op_a_q    <= '0;
      op_b_q    <= '0;
      lo_hold_q <= '0;
    end else begin
      if (accept) begin
        p_valid_q <= 1'b1;
        p_phase_q <= 1'b0;
        p_split_q <= cold_now && issue_wide_i;
        p_wide_q  <= issue_wide_i;
        p_lat_q   <= offer_lat;
        op_a_q    <= issue_a_i;
        op_b_q    <= issue_b_i;
      end else if (second_pend) begin
        p_phase_q <= 1'b1;
      end else begin
        p_valid_q <= 1'b0;
      end
      if (p_valid_q && !p_phase_q) lo_hold_q <= lo_sum;
    end
  end

  // second split pass routes the high operand half through the lower unit
  assign lo_a = p_phase_q ? op_a_q[DATA_W-1:HALF_W] : op_a_q[HALF_W-1:0];
  assign lo_b = p_phase_q ? op_b_q[DATA_W-1:HALF_W] : op_b_q[HALF_W-1:0];

  vws_lane_add #(.HALF_W(HALF_W), .LANE_W(LANE_W)) u_lo_unit (
    .a_i   (lo_a),
    .b_i   (lo_b),
    .sum_o (lo_sum)
  );

  vws_lane_add #(.HALF_W(HALF_W), .LANE_W(LANE_W)) u_hi_unit (
    .a_i   (op_a_q[DATA_W-1:HALF_W]),
    .b_i   (op_b_q[DATA_W-1:HALF_W]),
    .sum_o (hi_sum)
  );

  assign pass_valid_o = p_valid_q;
  assign pass_sel_o   = p_phase_q               ? 2'b10 :
                        (p_wide_q && !p_split_q) ? 2'b11 : 2'b01;

  assign wr      = p_valid_q && !(p_split_q && !p_phase_q);
  assign wr_idx  = p_lat_q - (p_split_q ? IDX_W'(3) : IDX_W'(2));
  assign wr_data = p_split_q ? {lo_sum, lo_hold_q} :
                   p_wide_q  ? {hi_sum, lo_sum}    : {{HALF_W{1'b0}}, lo_sum};

  vws_result_pipe #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .book_i      (accept),
    .book_idx_i  (offer_lat - IDX_W'(1)),
    .probe_idx_i (offer_lat),
    .busy_o      (slot_busy),
    .wr_i        (wr),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (wr_data),
    .res_valid_o (res_valid_o),
    .res_data_o  (res_data_o)
  );

  assign state_o = state;

  assert_split_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cold_now && issue_wide_i) |=> (!issue_ready_o && pass_valid_o && pass_sel_o == 2'b01));
  assert_split_second_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_valid_o && pass_sel_o == 2'b01 && !issue_ready_o) |=> (pass_valid_o && pass_sel_o == 2'b10));
  assert_warm_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !cold_now && issue_wide_i) |=> (pass_valid_o && pass_sel_o == 2'b11));
  assert_narrow_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !issue_wide_i) |=> (pass_valid_o && pass_sel_o == 2'b01));
  assert_cold_no_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_valid_o && p_split_q) |-> pass_sel_o != 2'b11);
endmodule

// File: tb/sim_vec_warm_seq.sv
`timescale 1ns/1ps
module sim_vec_warm_seq;
  localparam int HALF_W = 128, LANE_W = 32, WARM_LAT = 3, COLD_EXTRA = 2;
  localparam int WARMUP_CYC = 70, IDLE_CYC = 1024, DW = 2 * HALF_W;
  localparam int M_IDLE = 0, M_NARROW = 1, M_WIDE = 2, M_MIX = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_ni, issue_valid_i, issue_wide_i, issue_ready_o;
  logic [DW-1:0] issue_a_i, issue_b_i, res_data_o;
  logic          pass_valid_o, res_valid_o;
  logic [1:0]    pass_sel_o, state_o;

  vec_warm_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .issue_valid_i(issue_valid_i), .issue_wide_i(issue_wide_i),
    .issue_a_i(issue_a_i), .issue_b_i(issue_b_i), .issue_ready_o(issue_ready_o),
    .pass_valid_o(pass_valid_o), .pass_sel_o(pass_sel_o), .res_valid_o(res_valid_o),
    .res_data_o(res_data_o), .state_o(state_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, pend_cyc = -1;
  int m_st = 0, m_cnt = 0;
  bit done = 0, have_op = 0;
  logic          op_wide = 1'b0;
  logic [DW-1:0] op_a = '0, op_b = '0;
  logic [DW-1:0] exp_res [int];
  string         exp_res_req [int];
  logic [1:0]    exp_pass [int];
  string         exp_pass_req [int];

  function automatic logic [DW-1:0] lane_sum(logic [DW-1:0] a, logic [DW-1:0] b, logic wide);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < DW / LANE_W; i++)
      if (wide || i < HALF_W / LANE_W) r[i*LANE_W +: LANE_W] = a[i*LANE_W +: LANE_W] + b[i*LANE_W +: LANE_W];
    return r;
  endfunction

  function automatic logic [DW-1:0] rnd();
    logic [DW-1:0] r;
    for (int i = 0; i < DW / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic step(int mode);
    int lat;
    bit e_rdy, acc, cold;
    string sreq;
    @(negedge clk);
    if (mode == M_IDLE) have_op = 0;
    else if (!have_op) begin
      have_op = 1;
      op_wide = (mode == M_WIDE) ? 1'b1 : (mode == M_NARROW) ? 1'b0 : 1'($urandom % 2);
      op_a = rnd();
      op_b = rnd();
    end
    issue_valid_i = have_op;
    issue_wide_i  = op_wide;
    issue_a_i     = op_a;
    issue_b_i     = op_b;
    #1;
    cold  = (m_st != 2);
    lat   = !cold ? WARM_LAT : (op_wide ? WARM_LAT + COLD_EXTRA + 2 : WARM_LAT + COLD_EXTRA);
    e_rdy = (pend_cyc != cyc) && !exp_res.exists(cyc + lat);
    chk(issue_ready_o == e_rdy, (pend_cyc == cyc) ? "R3" : "R10", "issue_ready", DW'(issue_ready_o), DW'(e_rdy));
    sreq = (m_st == 1) ? "R2" : (m_st == 2 && m_cnt == 0) ? "R2" : (m_st == 2) ? "R8" : "R5";
    chk(state_o == 2'(m_st), sreq, "state", DW'(state_o), DW'(m_st));
    chk(state_o != 2'd3, "R11", "state encoding", DW'(state_o), DW'(0));
    if (exp_pass.exists(cyc)) begin
      chk(pass_valid_o && pass_sel_o == exp_pass[cyc], exp_pass_req[cyc], "pass",
          DW'({pass_valid_o, pass_sel_o}), DW'({1'b1, exp_pass[cyc]}));
      exp_pass.delete(cyc);
      exp_pass_req.delete(cyc);
    end else chk(!pass_valid_o, "R3", "idle pass", DW'(pass_valid_o), DW'(0));
    if (exp_res.exists(cyc)) begin
      chk(res_valid_o, exp_res_req[cyc], "result latency", DW'(res_valid_o), DW'(1));
      chk(res_data_o == exp_res[cyc], "R9", "result data", res_data_o, exp_res[cyc]);
      exp_res.delete(cyc);
      exp_res_req.delete(cyc);
    end else chk(!res_valid_o, "R10", "spurious result", DW'(res_valid_o), DW'(0));
    acc = have_op && e_rdy;
    if (acc) begin
      if (cold && op_wide) begin
        exp_pass[cyc+1] = 2'b01; exp_pass_req[cyc+1] = "R3";
        exp_pass[cyc+2] = 2'b10; exp_pass_req[cyc+2] = "R3";
        pend_cyc = cyc + 1;
      end else begin
        exp_pass[cyc+1] = op_wide ? 2'b11 : 2'b01;
        exp_pass_req[cyc+1] = op_wide ? "R4" : "R5";
      end
      exp_res[cyc+lat] = lane_sum(op_a, op_b, op_wide);
      // R7: an op taken before WARM keeps its cold latency even if WARM arrives first
      exp_res_req[cyc+lat] = (cold && m_st == 1 && m_cnt + lat > WARMUP_CYC) ? "R7" : "R6";
      have_op = 0;
    end
    case (m_st)
      0: if (acc && op_wide) begin m_st = 1; m_cnt = 0; end
      1: if (m_cnt == WARMUP_CYC - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
      default: if (acc) m_cnt = 0;
               else if (m_cnt == IDLE_CYC - 1) begin m_st = 0; m_cnt = 0; end
               else m_cnt++;
    endcase
    cyc++;
  endtask

  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) step(mode);
  endtask

  initial begin
    rst_ni = 1'b0; issue_valid_i = 1'b0; issue_wide_i = 1'b0; issue_a_i = '0; issue_b_i = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(state_o == 2'd0 && issue_ready_o && !pass_valid_o && !res_valid_o, "R1", "reset outputs",
        DW'({state_o, issue_ready_o, pass_valid_o, res_valid_o}), DW'({2'd0, 1'b1, 1'b0, 1'b0}));
    @(posedge clk);
    rst_ni = 1'b1;
    run(20, M_NARROW);
    run(6, M_IDLE);
    run(40, M_MIX);
    run(60, M_WIDE);
    run(30, M_MIX);
    run(10, M_IDLE);
    run(600, M_IDLE);
    run(1, M_NARROW);
    run(1100, M_IDLE);
    run(12, M_WIDE);
    run(15, M_NARROW);
    run(12, M_IDLE);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule